// File: doc/BRIEF.md
# Dual-Bank Valued Reservation Station

This block schedules work for a single functional unit. Each cycle the dispatcher may offer one micro-op with three source operands. For each source it supplies either a value that is ready to use or a pending reference: the id of the producing unit and a destination tag. Because every entry keeps operand values rather than register numbers, a launched micro-op goes to the functional unit with all of its data and needs no register-file read.

Entries live in two banks. The ready bank is cheap. It holds only micro-ops whose operands are all known at dispatch, and it has no wakeup or capture logic. The capture bank holds micro-ops that still wait on a result. It snoops the forwarding buses and latches each value whose unit id and tag match. Each cycle the oldest launchable entry in either bank is sent out and its slot is freed. A flush empties both banks at once.

Top module: `resv_station_2bank`

## Requirements
- R1: After reset both banks are empty, `iss_valid` is 0 and `disp_ready` is 1.
- R2: A micro-op whose three operands are all ready is written at the dispatch clock edge. It launches in the following cycle with its opcode and values intact, where source s sits at bits [s*W +: W] of `iss_src`. Its slot is freed at the next edge.
- R3: A pending operand in the capture bank latches a forwarding value only when both the bus unit id and the bus tag equal the recorded ones. A bus that matches on only one of the two has no effect.
- R4: A pending operand whose producer broadcasts during the dispatch cycle is taken from that bus as the entry is written. The micro-op then counts as fully ready.
- R5: An entry completed by a capture in cycle c does not launch in cycle c. It may launch in cycle c+1 at the earliest.
- R6: When several entries are launchable, the one dispatched earliest launches, whichever bank holds it.
- R7: A fully ready micro-op goes to the ready bank whenever that bank has a free slot, and to the capture bank only when the ready bank is full. A micro-op with any pending operand always goes to the capture bank. `disp_rdy[s]`=1 marks source s as a value.
- R8: When the selected bank has no free slot, `disp_ready` is 0 and the offered micro-op is not stored.
- R9: `flush` empties both banks at the next edge. A micro-op offered in the flush cycle is discarded.
- R10: At most one micro-op launches per cycle, and each stored micro-op launches exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries and the current offer |
| disp_valid | input | 1 | A micro-op is offered |
| disp_ready | output | 1 | The offered micro-op is accepted |
| disp_op | input | OPW | Opcode of the offered micro-op |
| disp_rdy | input | 3 | Per source: 1 = value given, 0 = pending |
| disp_val | input | 3*W | Source values, source s at [s*W +: W] |
| disp_unit | input | 3*UIDW | Producing unit id per pending source |
| disp_tag | input | 3*TAGW | Destination tag per pending source |
| fwd_valid | input | NFWD | Forwarding bus b is broadcasting |
| fwd_unit | input | NFWD*UIDW | Unit id per bus |
| fwd_tag | input | NFWD*TAGW | Destination tag per bus |
| fwd_data | input | NFWD*W | Result value per bus |
| iss_valid | output | 1 | A micro-op launches this cycle |
| iss_op | output | OPW | Opcode of the launching micro-op |
| iss_src | output | 3*W | Operand values of the launching micro-op |

## Verification
Each kind of internal corruption shows up at the ports within a few cycles:

- A bad capture compare either latches the wrong bus value or never wakes the entry. The first case puts a wrong operand on `iss_src` in the cycle after the broadcast. The second leaves a launch missing, which the bench sees when its queue of expected launches never drains.
- A corrupted age relation shows as launches in the wrong order.
- A slot that is wrongly freed or kept shows one cycle later. It appears either as a launch the bench did not expect, or as `disp_ready` dropping while a bank still has room.
- Flush and back-pressure faults show as a discarded micro-op launching later.

// File: rtl/resv_station_2bank.sv
`timescale 1ns/1ps
module resv_station_2bank #(
  parameter int W    = 16,
  parameter int OPW  = 6,
  parameter int UIDW = 2,
  parameter int TAGW = 4,
  parameter int NFWD = 2,
  parameter int SD   = 2,
  parameter int CD   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 disp_valid,
  output logic                 disp_ready,
  input  logic [OPW-1:0]       disp_op,
  input  logic [2:0]           disp_rdy,
  input  logic [3*W-1:0]       disp_val,
  input  logic [3*UIDW-1:0]    disp_unit,
  input  logic [3*TAGW-1:0]    disp_tag,
  input  logic [NFWD-1:0]      fwd_valid,
  input  logic [NFWD*UIDW-1:0] fwd_unit,
  input  logic [NFWD*TAGW-1:0] fwd_tag,
  input  logic [NFWD*W-1:0]    fwd_data,
  output logic                 iss_valid,
  output logic [OPW-1:0]       iss_op,
  output logic [3*W-1:0]       iss_src
);
  localparam int N   = SD + CD;
  localparam int SIW = (SD > 1) ? $clog2(SD) : 1;
  localparam int CIW = (CD > 1) ? $clog2(CD) : 1;
  localparam int NIW = (N > 1) ? $clog2(N) : 1;

  logic [SD-1:0]        svld;
  logic [OPW-1:0]       sop   [SD];
  logic [3*W-1:0]       sval  [SD];
  logic [CD-1:0]        cvld;
  logic [OPW-1:0]       cop   [CD];
  logic [3*W-1:0]       cval  [CD];
  logic [2:0]           crdy  [CD];
  logic [3*UIDW-1:0]    cunit [CD];
  logic [3*TAGW-1:0]    ctag  [CD];
  logic [N-1:0]         older [N];

  logic [2:0]           drdy;
  logic [3*W-1:0]       dval;
  logic [2:0]           chit  [CD];
  logic [3*W-1:0]       cnew  [CD];
  logic [CD-1:0]        cready;
  logic [N-1:0]         vld, erdy, pick;
  logic [SIW-1:0]       sidx;
  logic [CIW-1:0]       cidx;
  logic [NIW-1:0]       widx;
  logic                 to_s, to_c, wr_s, wr_c;

  always_comb begin
    drdy = disp_rdy;
    dval = disp_val;
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < NFWD; b++)
        if (!drdy[s] && fwd_valid[b] &&
            fwd_unit[b*UIDW +: UIDW] == disp_unit[s*UIDW +: UIDW] &&
            fwd_tag[b*TAGW +: TAGW] == disp_tag[s*TAGW +: TAGW]) begin
          drdy[s] = 1'b1;
          dval[s*W +: W] = fwd_data[b*W +: W];
        end
  end

  always_comb begin
    for (int c = 0; c < CD; c++) begin
      chit[c] = crdy[c];
      cnew[c] = cval[c];
      for (int s = 0; s < 3; s++)
        for (int b = 0; b < NFWD; b++)
          if (cvld[c] && !chit[c][s] && fwd_valid[b] &&
              fwd_unit[b*UIDW +: UIDW] == cunit[c][s*UIDW +: UIDW] &&
              fwd_tag[b*TAGW +: TAGW] == ctag[c][s*TAGW +: TAGW]) begin
            chit[c][s] = 1'b1;
            cnew[c][s*W +: W] = fwd_data[b*W +: W];
          end
      cready[c] = cvld[c] && (&crdy[c]);
    end
  end

  always_comb begin
    sidx = '0;
    cidx = '0;
    for (int i = SD-1; i >= 0; i--) if (!svld[i]) sidx = SIW'(i);
    for (int i = CD-1; i >= 0; i--) if (!cvld[i]) cidx = CIW'(i);
  end

  assign to_s       = (&drdy) && !(&svld);
  assign to_c       = !to_s && !(&cvld);
  assign disp_ready = to_s || to_c;
  assign wr_s       = disp_valid && to_s && !flush;
  assign wr_c       = disp_valid && to_c && !flush;
  assign widx       = wr_s ? NIW'(sidx) : NIW'(SD) + NIW'(cidx);

  assign vld  = {cvld, svld};
  assign erdy = {cready, svld};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pick[i] = erdy[i];
      for (int j = 0; j < N; j++)
        if (erdy[j] && older[j][i]) pick[i] = 1'b0;
    end
  end

  always_comb begin
    iss_op  = '0;
    iss_src = '0;
    for (int i = 0; i < SD; i++)
      if (pick[i]) begin iss_op = sop[i]; iss_src = sval[i]; end
    for (int c = 0; c < CD; c++)
      if (pick[SD+c]) begin iss_op = cop[c]; iss_src = cval[c]; end
  end
  assign iss_valid = |pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svld <= '0;
      cvld <= '0;
    end else if (flush) begin
      svld <= '0;
      cvld <= '0;
    end else begin
      svld <= svld & ~pick[SD-1:0];
      cvld <= cvld & ~pick[N-1:SD];
      if (wr_s) svld[sidx] <= 1'b1;
      if (wr_c) cvld[cidx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < CD; c++) begin
      crdy[c] <= chit[c];
      cval[c] <= cnew[c];
    end
    if (wr_s) begin
      sop[sidx]  <= disp_op;
      sval[sidx] <= dval;
    end
    if (wr_c) begin
      cop[cidx]   <= disp_op;
      cval[cidx]  <= dval;
      crdy[cidx]  <= drdy;
      cunit[cidx] <= disp_unit;
      ctag[cidx]  <= disp_tag;
    end
    if (wr_s || wr_c)
      for (int j = 0; j < N; j++) begin
        older[j][widx] <= vld[j];
        older[widx][j] <= 1'b0;
      end
  end
endmodule

// File: rtl/resv_station_2bank_chk.sv
`timescale 1ns/1ps
module resv_station_2bank_chk #(
  parameter int N  = 6,
  parameter int SD = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         disp_valid,
  input logic         disp_ready,
  input logic [2:0]   disp_rdy,
  input logic         iss_valid,
  input logic [N-1:0] vld,
  input logic [N-1:0] pick
);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0 && !iss_valid));

  // R8
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> ($countones(vld) <= $past($countones(vld))));

  // R10
  single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R7
  ready_bank_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && (&disp_rdy) && !(&vld[SD-1:0])) |-> disp_ready);

  // R2
  launch_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !flush && !(disp_valid && disp_ready)) |=>
      ($countones(vld) == $past($countones(vld)) - 1));
endmodule

bind resv_station_2bank resv_station_2bank_chk #(.N(SD + CD), .SD(SD)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_rdy(disp_rdy), .iss_valid(iss_valid),
  .vld(vld), .pick(pick)
);

// File: tb/resv_station_2bank_bench.sv
`timescale 1ns/1ps
module resv_station_2bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [5:0]  disp_op = '0;
  logic [2:0]  disp_rdy = '0;
  logic [47:0] disp_val = '0;
  logic [5:0]  disp_unit = '0;
  logic [11:0] disp_tag = '0;
  logic [1:0]  fwd_valid = '0;
  logic [3:0]  fwd_unit = '0;
  logic [7:0]  fwd_tag = '0;
  logic [31:0] fwd_data = '0;
  logic        iss_valid;
  logic [5:0]  iss_op;
  logic [47:0] iss_src;

  int checks = 0;
  int fails = 0;
  logic [53:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  resv_station_2bank u_resv_station_2bank (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_rdy(disp_rdy), .disp_val(disp_val), .disp_unit(disp_unit),
    .disp_tag(disp_tag), .fwd_valid(fwd_valid), .fwd_unit(fwd_unit),
    .fwd_tag(fwd_tag), .fwd_data(fwd_data), .iss_valid(iss_valid),
    .iss_op(iss_op), .iss_src(iss_src)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_launch(input logic [5:0] op, input logic [47:0] src, input string req);
    exp_q.push_back({op, src});
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && iss_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected launch", {10'd0, iss_op, iss_src}, 64'd0);
      end else begin
        logic [53:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        chk({iss_op, iss_src} == e, r, {10'd0, iss_op, iss_src}, {10'd0, e});
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    fwd_valid = '0;
    flush = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    chk(iss_valid == 1'b0, req, {63'd0, iss_valid}, 64'd0);
    tick();
  endtask

  task automatic set_fwd(input int b, input logic [1:0] u, input logic [3:0] t, input logic [15:0] d);
    fwd_valid[b] = 1'b1;
    fwd_unit[b*2 +: 2] = u;
    fwd_tag[b*4 +: 4] = t;
    fwd_data[b*16 +: 16] = d;
  endtask

  task automatic disp(input logic [5:0] op, input logic [2:0] rdy, input logic [47:0] vals,
                      input logic [5:0] units, input logic [11:0] tags, output logic acc);
    disp_valid = 1'b1;
    disp_op = op;
    disp_rdy = rdy;
    disp_val = vals;
    disp_unit = units;
    disp_tag = tags;
    @(negedge clk);
    acc = disp_ready;
    tick();
    disp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(iss_valid == 1'b0, "R1 iss_valid after reset", {63'd0, iss_valid}, 64'd0);
    chk(disp_ready == 1'b1, "R1 disp_ready after reset", {63'd0, disp_ready}, 64'd1);
    tick();

    // R2 fully ready micro-op
    expect_launch(6'd1, 48'h3333_2222_1111, "R2 ready launch");
    disp(6'd1, 3'b111, 48'h3333_2222_1111, '0, '0, a);
    tick();
    idle_chk("R2 slot freed after launch");

    // R3 capture needs unit and tag match; R5 launch one cycle after capture
    expect_launch(6'd2, 48'h0003_0002_abcd, "R3 captured value");
    disp(6'd2, 3'b110, 48'h0003_0002_0000, 6'b00_00_01, 12'h005, a);
    set_fwd(0, 2'd2, 4'd5, 16'h9999);
    idle_chk("R3 unit mismatch ignored");
    set_fwd(1, 2'd1, 4'd4, 16'h8888);
    idle_chk("R3 tag mismatch ignored");
    set_fwd(0, 2'd1, 4'd5, 16'habcd);
    idle_chk("R5 no launch in capture cycle");
    tick();
    tick();

    // R4 capture at dispatch
    expect_launch(6'd3, 48'h0013_7777_0011, "R4 dispatch-time capture");
    set_fwd(1, 2'd3, 4'd7, 16'h7777);
    disp(6'd3, 3'b101, 48'h0013_0000_0011, 6'b00_11_00, 12'h070, a);
    chk(a == 1'b1, "R4 accepted", {63'd0, a}, 64'd1);
    tick();
    tick();

    // R6 oldest first across banks, R7 fallback to capture bank
    expect_launch(6'd4, 48'h0101_0001_00a0, "R6 order A");
    expect_launch(6'd5, 48'h0101_0001_00b0, "R6 order B");
    expect_launch(6'd6, 48'h0101_0001_00c0, "R6 order C");
    expect_launch(6'd7, 48'h0007_0007_0007, "R6 order D");
    expect_launch(6'd8, 48'h0008_0008_0008, "R6 order E");
    expect_launch(6'd9, 48'h0009_0009_0009, "R7 fallback F");
    disp(6'd4, 3'b011, 48'h0000_0001_00a0, 6'b00_00_00, 12'h100, a);
    disp(6'd5, 3'b011, 48'h0000_0001_00b0, 6'b00_00_00, 12'h100, a);
    disp(6'd6, 3'b011, 48'h0000_0001_00c0, 6'b00_00_00, 12'h100, a);
    set_fwd(0, 2'd0, 4'd1, 16'h0101);
    disp(6'd7, 3'b111, 48'h0007_0007_0007, '0, '0, a);
    disp(6'd8, 3'b111, 48'h0008_0008_0008, '0, '0, a);
    disp(6'd9, 3'b111, 48'h0009_0009_0009, '0, '0, a);
    chk(a == 1'b1, "R7 ready bank full, capture bank takes it", {63'd0, a}, 64'd1);
    repeat (8) tick();

    // R8 capture bank full
    expect_launch(6'd15, 48'h000f_000f_000f, "R8 ready bank still open");
    expect_launch(6'd10, 48'h0010_0010_0909, "R8 stored G");
    expect_launch(6'd11, 48'h0011_0011_0909, "R8 stored H");
    expect_launch(6'd12, 48'h0012_0012_0909, "R8 stored I");
    expect_launch(6'd13, 48'h0013_0013_0909, "R8 stored J");
    disp(6'd10, 3'b110, 48'h0010_0010_0000, 6'b00_00_10, 12'h009, a);
    disp(6'd11, 3'b110, 48'h0011_0011_0000, 6'b00_00_10, 12'h009, a);
    disp(6'd12, 3'b110, 48'h0012_0012_0000, 6'b00_00_10, 12'h009, a);
    disp(6'd13, 3'b110, 48'h0013_0013_0000, 6'b00_00_10, 12'h009, a);
    disp(6'd14, 3'b110, 48'h0014_0014_0000, 6'b00_00_10, 12'h009, a);
    chk(a == 1'b0, "R8 disp_ready low when capture bank full", {63'd0, a}, 64'd0);
    disp(6'd15, 3'b111, 48'h000f_000f_000f, '0, '0, a);
    chk(a == 1'b1, "R8 ready micro-op accepted", {63'd0, a}, 64'd1);
    set_fwd(1, 2'd2, 4'd9, 16'h0909);
    tick();
    repeat (8) tick();

    // R9 flush
    disp(6'd16, 3'b110, 48'h0016_0016_0000, 6'b00_00_01, 12'h003, a);
    disp(6'd17, 3'b110, 48'h0017_0017_0000, 6'b00_00_01, 12'h003, a);
    flush = 1'b1;
    disp(6'd18, 3'b111, 48'h0018_0018_0018, '0, '0, a);
    idle_chk("R9 offer in flush cycle dropped");
    set_fwd(0, 2'd1, 4'd3, 16'h0303);
    idle_chk("R9 flushed entries gone");
    idle_chk("R9 no late launch");
    expect_launch(6'd19, 48'h0019_0019_0019, "R9 works after flush");
    disp(6'd19, 3'b111, 48'h0019_0019_0019, '0, '0, a);
    repeat (3) tick();

    chk(exp_q.size() == 0, "R10 every stored micro-op launched once", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule